// File: doc/BRIEF.md
# Phase-Accumulator Multi-Waveform Oscillator

This block is a digital tone generator. A 24-bit phase accumulator advances by a programmable 16-bit step on every clock. The top twelve bits of the phase are shaped into a sawtooth, a triangle or a pulse word. A 12-bit noise word, produced by a separate block, can also be gated onto the output. When more than one shape is enabled, the output is the bitwise AND of all the enabled shapes.

Byte-wide writes program the step, the pulse threshold and a control byte. The control byte holds the shape enables and three mode bits:
- **Halt** clears the phase and holds it at zero.
- **Hard sync** restarts the phase when a companion oscillator's phase MSB rises.
- **Ring** folds the triangle on the XOR of its own MSB and the companion's MSB.

The block exports its own phase MSB and a one-cycle MSB-rising strobe, so that a neighbouring oscillator can sync or ring-modulate against it. When no shape is enabled, the output word floats: it keeps its last value for a fixed number of clocks and then falls to zero.

Top module: `tone_osc`

## Requirements
- R1: On each clock where halt is clear and no sync restart occurs, the phase becomes (phase + step) mod 2^24. A write takes effect on the clock after the write edge.
- R2: While halt (control bit 0) is set, the phase is cleared to zero and stays there. Counting resumes from zero once halt is cleared.
- R3: With only sawtooth enabled (control bit 5), `wave_out` equals phase bits [23:12], one clock after the phase register.
- R4: With only triangle enabled (control bit 4), `wave_out` is phase bits [22:12] shifted left by one with bit 0 zero. The 11 bits are inverted when the effective MSB is 1.
- R5: When ring (control bit 2) is set, the triangle's effective MSB is phase bit 23 XOR `comp_msb`. When ring is clear, it is phase bit 23 alone.
- R6: With only pulse enabled (control bit 6), `wave_out` is 0xFFF when phase[23:12] >= the threshold, and 0x000 otherwise. The comparison reaches the output one clock later than the sawtooth would.
- R7: While halt is set, the pulse level is forced high, so a pulse-enabled output reads 0xFFF whatever the threshold.
- R8: `msb_rise` is high for exactly the clock following an update in which phase bit 23 went from 0 to 1. `acc_msb` always shows phase bit 23.
- R9: Address 0 writes step[7:0] and address 1 writes step[15:8]. Address 2 writes threshold[7:0]. Address 3 writes threshold[11:8] from data[3:0], and data[7:4] is ignored. Address 4 writes the control byte.
- R10: When sync (control bit 1) is set and `comp_msb_rise` is high, the next phase is zero.
- R11: With several shapes enabled, `wave_out` is the bitwise AND of the enabled shapes. Noise is control bit 7 and comes from `noise_in`.
- R12: With no shape enabled, `wave_out` holds its last value for FLOAT_TTL clocks and becomes zero on the following clock.
- R13: After reset, all registers are zero, and `wave_out`, `acc_msb` and `msb_rise` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write byte |
| comp_msb | input | 1 | Companion oscillator phase MSB |
| comp_msb_rise | input | 1 | Companion oscillator MSB-rising strobe |
| noise_in | input | 12 | Noise word from the external noise block |
| wave_out | output | 12 | Shaped waveform word |
| acc_msb | output | 1 | Own phase MSB |
| msb_rise | output | 1 | Own MSB-rising strobe |

## Verification
A small step and the full 0xFFFF step are run with the sawtooth. The small step shows plain accumulation. The full step shows wrap and MSB-rise strobes at a known rate.

The triangle is run with ring off, and then with a toggling companion MSB. This separates folding on the own MSB from folding on the XOR. The pulse is run with a mid-scale threshold written with junk in the high nibble. This exposes both the one-clock compare delay and the nibble masking.

Halt is applied under pulse and under sawtooth, to tell the forced-high pulse apart from the zeroed phase. Periodic companion strobes with sync set, and then with sync clear, show that the restart happens only when sync is set. Paired shapes with random noise check the AND. Deselecting all shapes shows the hold period and the drop to zero.

// File: rtl/osc_pkg.sv
package osc_pkg;

  localparam logic [2:0] ADDR_STEP_LO = 3'd0;
  localparam logic [2:0] ADDR_STEP_HI = 3'd1;
  localparam logic [2:0] ADDR_THR_LO  = 3'd2;
  localparam logic [2:0] ADDR_THR_HI  = 3'd3;
  localparam logic [2:0] ADDR_CTRL    = 3'd4;

  localparam int SHAPE_N   = 4;
  localparam int SHAPE_TRI = 0;
  localparam int SHAPE_SAW = 1;
  localparam int SHAPE_PUL = 2;
  localparam int SHAPE_NOI = 3;

  typedef struct packed {
    logic [SHAPE_N-1:0] shape_en;
    logic               ring;
    logic               sync;
    logic               halt;
  } osc_ctrl_t;

endpackage

// File: rtl/osc_regs.sv
module osc_regs
  import osc_pkg::*;
#(
  parameter int STEP_W = 16,
  parameter int THR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic [STEP_W-1:0] step,
  output logic [THR_W-1:0]  thr,
  output osc_ctrl_t         ctrl
);

  localparam int STEP_HI_W = STEP_W - 8;
  localparam int THR_HI_W  = THR_W - 8;

  logic [STEP_W-1:0] step_d, step_q;
  logic [THR_W-1:0]  thr_d, thr_q;
  osc_ctrl_t         ctrl_d, ctrl_q;

  always_comb begin
    step_d = step_q;
    thr_d  = thr_q;
    ctrl_d = ctrl_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_STEP_LO: step_d[7:0]        = wr_data;
        ADDR_STEP_HI: step_d[STEP_W-1:8] = wr_data[STEP_HI_W-1:0];
        ADDR_THR_LO:  thr_d[7:0]         = wr_data;
        ADDR_THR_HI:  thr_d[THR_W-1:8]   = wr_data[THR_HI_W-1:0];
        ADDR_CTRL: begin
          ctrl_d.shape_en = wr_data[7:4];
          ctrl_d.ring     = wr_data[2];
          ctrl_d.sync     = wr_data[1];
          ctrl_d.halt     = wr_data[0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      thr_q  <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      step_q <= step_d;
      thr_q  <= thr_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign step = step_q;
  assign thr  = thr_q;
  assign ctrl = ctrl_q;

endmodule

// File: rtl/osc_phase.sv
module osc_phase #(
  parameter int ACC_W  = 24,
  parameter int STEP_W = 16,
  parameter int THR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] step,
  input  logic [THR_W-1:0]  thr,
  input  logic              halt,
  input  logic              sync,
  input  logic              comp_rise,
  output logic [ACC_W-1:0]  acc,
  output logic              pulse_hi,
  output logic              rise
);

  localparam int PAD_W = ACC_W - STEP_W;

  logic [ACC_W-1:0] acc_d, acc_q;
  logic             pulse_d, pulse_q;
  logic             rise_d, rise_q;
  logic             restart;

  assign restart = halt | (sync & comp_rise);

  always_comb begin
    if (restart) acc_d = '0;
    else         acc_d = acc_q + {{PAD_W{1'b0}}, step};
    rise_d  = ~acc_q[ACC_W-1] & acc_d[ACC_W-1];
    pulse_d = halt | (acc_q[ACC_W-1 -: THR_W] >= thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      pulse_q <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      pulse_q <= pulse_d;
      rise_q  <= rise_d;
    end
  end

  assign acc      = acc_q;
  assign pulse_hi = pulse_q;
  assign rise     = rise_q;

endmodule

// File: rtl/osc_shaper.sv
module osc_shaper
  import osc_pkg::*;
#(
  parameter int OUT_W     = 12,
  parameter int FLOAT_TTL = 16,
  parameter int TTL_W     = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OUT_W-1:0]   phase,
  input  logic               ring_msb,
  input  logic [SHAPE_N-1:0] shape_en,
  input  logic               pulse_hi,
  input  logic [OUT_W-1:0]   noise,
  output logic [OUT_W-1:0]   wave
);

  logic [OUT_W-1:0] src    [SHAPE_N];
  logic [OUT_W-1:0] masked [SHAPE_N];
  logic [OUT_W-1:0] combined;
  logic             fold;
  logic [OUT_W-2:0] tri_low;
  logic             any_en;
  logic             wave_en;
  logic [OUT_W-1:0] wave_d, wave_q;
  logic [TTL_W-1:0] ttl_d, ttl_q;

  assign fold    = phase[OUT_W-1] ^ ring_msb;
  assign tri_low = phase[OUT_W-2:0] ^ {(OUT_W-1){fold}};

  assign src[SHAPE_TRI] = {tri_low, 1'b0};
  assign src[SHAPE_SAW] = phase;
  assign src[SHAPE_PUL] = {OUT_W{pulse_hi}};
  assign src[SHAPE_NOI] = noise;

  for (genvar g = 0; g < SHAPE_N; g++) begin : g_mask
    assign masked[g] = shape_en[g] ? src[g] : {OUT_W{1'b1}};
  end

  always_comb begin
    combined = {OUT_W{1'b1}};
    for (int i = 0; i < SHAPE_N; i++) combined &= masked[i];
  end

  assign any_en  = |shape_en;
  assign wave_en = any_en | (ttl_q == '0);

  always_comb begin
    if (any_en) begin
      ttl_d  = TTL_W'(FLOAT_TTL);
      wave_d = combined;
    end else begin
      ttl_d  = (ttl_q == '0) ? ttl_q : ttl_q - 1'b1;
      wave_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ttl_q  <= '0;
      wave_q <= '0;
    end else begin
      ttl_q <= ttl_d;
      if (wave_en) wave_q <= wave_d;
    end
  end

  assign wave = wave_q;

endmodule

// File: rtl/tone_osc.sv
module tone_osc
  import osc_pkg::*;
#(
  parameter int ACC_W     = 24,
  parameter int STEP_W    = 16,
  parameter int THR_W     = 12,
  parameter int OUT_W     = 12,
  parameter int FLOAT_TTL = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             comp_msb,
  input  logic             comp_msb_rise,
  input  logic [OUT_W-1:0] noise_in,
  output logic [OUT_W-1:0] wave_out,
  output logic             acc_msb,
  output logic             msb_rise
);

  localparam int TTL_W = $clog2(FLOAT_TTL + 1);

  logic [STEP_W-1:0]  step;
  logic [THR_W-1:0]   thr;
  osc_ctrl_t          ctrl;
  logic               halt_bit, sync_bit, ring_bit;
  logic [SHAPE_N-1:0] shape_en;
  logic [ACC_W-1:0]   acc;
  logic               pulse_hi;

  assign halt_bit = ctrl.halt;
  assign sync_bit = ctrl.sync;
  assign ring_bit = ctrl.ring;
  assign shape_en = ctrl.shape_en;

  osc_regs #(.STEP_W(STEP_W), .THR_W(THR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .step(step), .thr(thr), .ctrl(ctrl)
  );

  osc_phase #(.ACC_W(ACC_W), .STEP_W(STEP_W), .THR_W(THR_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .step(step), .thr(thr), .halt(halt_bit),
    .sync(sync_bit), .comp_rise(comp_msb_rise), .acc(acc),
    .pulse_hi(pulse_hi), .rise(msb_rise)
  );

  osc_shaper #(.OUT_W(OUT_W), .FLOAT_TTL(FLOAT_TTL), .TTL_W(TTL_W)) u_shape (
    .clk(clk), .rst_n(rst_n), .phase(acc[ACC_W-1 -: OUT_W]),
    .ring_msb(ring_bit & comp_msb), .shape_en(shape_en),
    .pulse_hi(pulse_hi), .noise(noise_in), .wave(wave_out)
  );

  assign acc_msb = acc[ACC_W-1];

endmodule

// File: rtl/osc_checker.sv
module osc_checker #(
  parameter int ACC_W = 24,
  parameter int OUT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halt_bit,
  input logic             sync_bit,
  input logic [3:0]       shape_en,
  input logic             comp_msb_rise,
  input logic [ACC_W-1:0] acc,
  input logic             pulse_hi,
  input logic             msb_rise,
  input logic [OUT_W-1:0] wave_out
);

  p_halt_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    halt_bit |=> (acc == '0));

  p_halt_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_bit |=> pulse_hi);

  p_rise_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msb_rise |-> (acc[ACC_W-1] && !$past(acc[ACC_W-1])));

  p_sync_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_bit && comp_msb_rise) |=> (acc == '0));

  p_saw_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shape_en == 4'b0010) |=> (wave_out == $past(acc[ACC_W-1 -: OUT_W])));

  p_float_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (shape_en == 4'b0000) |=> (wave_out == $past(wave_out) || wave_out == '0));

endmodule

bind tone_osc osc_checker #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt_bit(halt_bit), .sync_bit(sync_bit),
  .shape_en(shape_en), .comp_msb_rise(comp_msb_rise), .acc(acc),
  .pulse_hi(pulse_hi), .msb_rise(msb_rise), .wave_out(wave_out)
);

// File: tb/tb_tone_osc.sv
module tb_tone_osc;

  localparam int TTL = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        comp_msb = 1'b0;
  logic        comp_msb_rise = 1'b0;
  logic [11:0] noise_in = '0;
  logic [11:0] wave_out;
  logic        acc_msb;
  logic        msb_rise;

  int n_tests = 0;
  int n_fail  = 0;
  string cur_req = "R13";
  bit done = 0;

  tone_osc #(.FLOAT_TTL(TTL)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .comp_msb(comp_msb), .comp_msb_rise(comp_msb_rise),
    .noise_in(noise_in), .wave_out(wave_out), .acc_msb(acc_msb),
    .msb_rise(msb_rise)
  );

  always #2 clk = ~clk;

  // Behavioural reference model, advanced on every rising edge
  logic [31:0] m_acc, m_step, m_thr, m_ttl;
  logic [7:0]  m_ctrl;
  logic        m_pulse, m_rise;
  logic [11:0] m_wave;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_step = 0; m_thr = 0; m_ttl = 0; m_ctrl = 0;
      m_pulse = 0; m_rise = 0; m_wave = 0;
    end else begin
      logic [31:0] nacc, ph, comb, tri_v;
      logic        eff;
      nacc = (m_acc + m_step) & 32'hFFFFFF;
      if (m_ctrl[0] || (m_ctrl[1] && comp_msb_rise)) nacc = 0;
      ph   = m_acc >> 12;
      eff  = ph[11] ^ (m_ctrl[2] & comp_msb);
      tri_v = eff ? (((~ph) & 32'h7FF) << 1) : ((ph & 32'h7FF) << 1);
      comb = 32'hFFF;
      if (m_ctrl[4]) comb &= tri_v;
      if (m_ctrl[5]) comb &= ph;
      if (m_ctrl[6]) comb &= (m_pulse ? 32'hFFF : 32'h0);
      if (m_ctrl[7]) comb &= {20'h0, noise_in};
      if (m_ctrl[7:4] != 0) begin
        m_wave = comb[11:0]; m_ttl = TTL;
      end else if (m_ttl != 0) m_ttl = m_ttl - 1;
      else m_wave = 0;
      m_rise  = !m_acc[23] && nacc[23];
      m_pulse = m_ctrl[0] || (ph >= m_thr);
      m_acc   = nacc;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_step[7:0]  = wr_data;
          3'd1: m_step[15:8] = wr_data;
          3'd2: m_thr[7:0]   = wr_data;
          3'd3: m_thr[11:8]  = wr_data[3:0];
          3'd4: m_ctrl       = wr_data;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "wave_out", {20'h0, wave_out}, {20'h0, m_wave});
      check(cur_req, "acc_msb", {31'h0, acc_msb}, {31'h0, m_acc[23]});
      check(cur_req, "msb_rise", {31'h0, msb_rise}, {31'h0, m_rise});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R13", "reset wave", {20'h0, wave_out}, 32'h0);
    check("R13", "reset msb", {31'h0, acc_msb}, 32'h0);
    check("R13", "reset rise", {31'h0, msb_rise}, 32'h0);

    cur_req = "R1";
    wr(3'd0, 8'h34); wr(3'd1, 8'h12); wr(3'd4, 8'h20);
    run(300);

    cur_req = "R3";  // full-scale step, wrap and R8 strobes
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
    run(600);

    cur_req = "R4";
    wr(3'd4, 8'h10);
    run(400);

    cur_req = "R5";
    wr(3'd4, 8'h14);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (i % 37 == 0) comp_msb = ~comp_msb;
    end
    comp_msb = 1'b0;

    cur_req = "R9";  // threshold high byte junk in [7:4]
    wr(3'd2, 8'h00); wr(3'd3, 8'hF8);
    cur_req = "R6";
    wr(3'd4, 8'h40);
    run(600);

    cur_req = "R7";
    wr(3'd2, 8'hFF); wr(3'd3, 8'h0F);
    wr(3'd4, 8'h41);
    run(5);
    check("R7", "halted pulse", {20'h0, wave_out}, 32'hFFF);
    wr(3'd4, 8'h40);
    run(50);

    cur_req = "R2";
    wr(3'd4, 8'h21);
    run(5);
    check("R2", "halted saw", {20'h0, wave_out}, 32'h0);
    check("R2", "halted msb", {31'h0, acc_msb}, 32'h0);
    wr(3'd4, 8'h20);
    run(100);

    cur_req = "R10";
    wr(3'd0, 8'h00); wr(3'd1, 8'h40);
    wr(3'd4, 8'h22);
    for (int i = 0; i < 400; i++) begin
      comp_msb_rise = (i % 50 == 49);
      @(negedge clk);
    end
    comp_msb_rise = 1'b0;
    wr(3'd4, 8'h20);
    for (int i = 0; i < 200; i++) begin
      comp_msb_rise = (i % 50 == 49);
      @(negedge clk);
    end
    comp_msb_rise = 1'b0;

    cur_req = "R11";
    wr(3'd0, 8'h77); wr(3'd1, 8'h93);
    wr(3'd2, 8'h00); wr(3'd3, 8'h06);
    foreach (noise_in[k]) ;
    for (int s = 0; s < 4; s++) begin
      case (s)
        0: wr(3'd4, 8'h30);
        1: wr(3'd4, 8'h60);
        2: wr(3'd4, 8'hA0);
        default: wr(3'd4, 8'hD0);
      endcase
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        noise_in = 12'($urandom);
      end
    end

    cur_req = "R12";
    wr(3'd4, 8'h20);
    run(20);
    wr(3'd4, 8'h00);
    run(TTL + 6);
    check("R12", "floated to zero", {20'h0, wave_out}, 32'h0);
    run(10);

    finish_up();
  end

endmodule